// File: doc/BRIEF.md
# ATA Status Fault Sorter

This block sits beside the register interface of a disk host controller. Each time the controller samples the device Status and Error registers, it presents the two bytes with a strobe. It also presents the current command phase, whether the command is ATA or ATAPI, and whether the final byte of the command packet (CDB) has gone out. One cycle later the block reports exactly one outcome class for that sample.

The meaning of a register pattern depends on where the command is. An error bit seen while the packet is still being written is a protocol breach. The same bit after the packet has completed is a check condition, and after a plain ATA command it is a device error. When the device protocol has been broken, a sticky flag tells recovery firmware that the port needs a reset. The flag holds until firmware pulses a clear.

Top module: `ata_fault_sorter`

## Requirements
- R1: Result timing and encoding. A sample strobed in one cycle produces `cls_valid_o` high in the next cycle, with exactly one bit of `cls_o` set. The class bits are: 0 normal, 1 protocol (HSM) violation, 2 device error, 3 check condition, 4 media error, 5 address error, 6 bus error. With no strobe, the next cycle has `cls_valid_o` low and `cls_o` zero. Phase codes are 0 issue, 1 packet acknowledge, 2 PIO data, 3 CDB transfer and 4 completion. Status bits are BSY 7, DRDY 6, DRQ 3 and ERR 0. Error bits are ICRC 7, UNC 6, IDNF 4 and ABRT 2. All other bits are ignored.
- R2: Issue phase. The result is normal only when BSY is clear, DRDY is set and DRQ is clear. Every other status gives a protocol violation.
- R3: PIO data phase. With ERR clear, a status with both BSY and DRQ clear is a protocol violation. Any other status is normal.
- R4: Completion phase. DRQ set is a protocol violation, whatever the ERR and Error register values are.
- R5: Packet phases. In the CDB transfer phase, BSY clear with ERR set before the last CDB byte is a protocol violation. The same pattern in the PIO data or completion phase of an ATAPI command, before the last CDB byte, is also a protocol violation. A command flagged ATA that shows up in phase 1 or 3 is a protocol violation.
- R6: Packet acknowledge phase of an ATAPI command. BSY clear with ERR and ABRT set is a device error (packet command refused). BSY clear with ERR set and ABRT clear is a protocol violation. Any other status is normal.
- R7: ATAPI error after the last CDB byte. BSY clear with ERR set, in phase 2, 3 or 4, is a check condition regardless of ABRT or any other Error bit.
- R8: ATA command, BSY clear with ERR set in the PIO data or completion phase. The first match in this order decides the class: ICRC gives bus error, UNC gives media error, IDNF gives address error. Otherwise the class is device error.
- R9: `reset_req_o` is low after reset. It is set by every protocol-violation result and stays set until `reset_clr_i` is pulsed. A violation strobed in the same cycle as a clear leaves it set.
- R10: Phase codes 5 to 7 are protocol violations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Status/Error sample strobe |
| phase_i | input | 3 | Command phase code |
| atapi_i | input | 1 | Command is ATAPI (packet) |
| cdb_done_i | input | 1 | Last CDB byte has been sent |
| status_i | input | 8 | Sampled Status register |
| error_i | input | 8 | Sampled Error register |
| reset_clr_i | input | 1 | Clears the reset-required flag |
| cls_valid_o | output | 1 | Class result strobe |
| cls_o | output | 7 | One-hot outcome class |
| reset_req_o | output | 1 | Sticky port-reset-required flag |

## Verification
The bench sweeps every phase code, both command types, both CDB-progress values, all sixteen combinations of the four decoded status bits and all sixteen combinations of the four decoded error bits. The ignored bits are filled with a changing pattern. Several corner cases are checked:
- DRQ at completion together with ERR. A design that let ERR win would report a device error where a reset is needed.
- ERR with ABRT before versus after the last CDB byte. Getting this wrong either forces a needless reset on a check condition or hides a broken packet exchange.
- ICRC, UNC and IDNF set together. A wrong priority misreports a cable fault as a media error.
- Clear pulses that land in the same cycle as a violation, and clear pulses with no strobe. A flag that cleared there would lose a pending reset.

// File: rtl/ata_fault_pkg.sv
package ata_fault_pkg;
  localparam int ST_W = 8;
  localparam int ER_W = 8;
  localparam int PH_W = 3;

  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam int ER_ICRC = 7;
  localparam int ER_UNC  = 6;
  localparam int ER_IDNF = 4;
  localparam int ER_ABRT = 2;

  localparam logic [PH_W-1:0] PH_ISSUE   = 3'd0;
  localparam logic [PH_W-1:0] PH_PKT_ACK = 3'd1;
  localparam logic [PH_W-1:0] PH_PIO     = 3'd2;
  localparam logic [PH_W-1:0] PH_CDB     = 3'd3;
  localparam logic [PH_W-1:0] PH_DONE    = 3'd4;

  typedef enum logic [2:0] {
    CL_OK    = 3'd0,
    CL_HSM   = 3'd1,
    CL_DEV   = 3'd2,
    CL_CHK   = 3'd3,
    CL_MEDIA = 3'd4,
    CL_ADDR  = 3'd5,
    CL_BUS   = 3'd6
  } cls_e;

  localparam int N_CLS = 7;

  typedef struct packed {
    logic bsy;
    logic drdy;
    logic drq;
    logic err;
    logic icrc;
    logic unc;
    logic idnf;
    logic abrt;
  } flags_t;
endpackage

// File: rtl/ata_flag_extract.sv
module ata_flag_extract
  import ata_fault_pkg::*;
#(
  parameter int SW = ST_W,
  parameter int EW = ER_W
) (
  input  logic [SW-1:0] status_i,
  input  logic [EW-1:0] error_i,
  output flags_t        flags_o
);
  always_comb begin
    flags_o.bsy  = status_i[ST_BSY];
    flags_o.drdy = status_i[ST_DRDY];
    flags_o.drq  = status_i[ST_DRQ];
    flags_o.err  = status_i[ST_ERR];
    flags_o.icrc = error_i[ER_ICRC];
    flags_o.unc  = error_i[ER_UNC];
    flags_o.idnf = error_i[ER_IDNF];
    flags_o.abrt = error_i[ER_ABRT];
  end

  // remaining register bits carry no meaning for classification
  logic unused_bits;
  assign unused_bits = ^{status_i[5:4], status_i[2:1], error_i[5], error_i[3], error_i[1:0]};
endmodule

// File: rtl/ata_phase_rules.sv
module ata_phase_rules
  import ata_fault_pkg::*;
(
  input  logic [PH_W-1:0] phase_i,
  input  logic            atapi_i,
  input  logic            cdb_done_i,
  input  flags_t          flags_i,
  output cls_e            cls_o
);
  function automatic cls_e ata_sub(input flags_t f);
    if (f.icrc)      return CL_BUS;
    else if (f.unc)  return CL_MEDIA;
    else if (f.idnf) return CL_ADDR;
    else             return CL_DEV;
  endfunction

  logic err_seen;
  logic ready;
  cls_e exec_err;

  assign err_seen = !flags_i.bsy && flags_i.err;
  assign ready    = !flags_i.bsy && flags_i.drdy && !flags_i.drq;

  // error seen while executing: meaning depends on command type and CDB progress
  always_comb begin
    if (!atapi_i)        exec_err = ata_sub(flags_i);
    else if (cdb_done_i) exec_err = CL_CHK;
    else                 exec_err = CL_HSM;
  end

  always_comb begin
    cls_o = CL_HSM;
    case (phase_i)
      PH_ISSUE:   cls_o = ready ? CL_OK : CL_HSM;
      PH_PKT_ACK: begin
        if (!atapi_i)       cls_o = CL_HSM;
        else if (!err_seen) cls_o = CL_OK;
        else if (flags_i.abrt) cls_o = CL_DEV;
        else                cls_o = CL_HSM;
      end
      PH_PIO: begin
        if (err_seen)                         cls_o = exec_err;
        else if (!flags_i.bsy && !flags_i.drq) cls_o = CL_HSM;
        else                                  cls_o = CL_OK;
      end
      PH_CDB: begin
        if (!atapi_i)      cls_o = CL_HSM;
        else if (err_seen) cls_o = cdb_done_i ? CL_CHK : CL_HSM;
        else               cls_o = CL_OK;
      end
      PH_DONE: begin
        if (flags_i.drq)   cls_o = CL_HSM;
        else if (err_seen) cls_o = exec_err;
        else               cls_o = CL_OK;
      end
      default: cls_o = CL_HSM;
    endcase
  end
endmodule

// File: rtl/ata_class_reg.sv
module ata_class_reg
  import ata_fault_pkg::*;
#(
  parameter int NC = N_CLS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  cls_e          cls_i,
  input  logic          clr_i,
  output logic          vld_o,
  output logic [NC-1:0] onehot_o,
  output logic          rreq_o
);
  logic [NC-1:0] onehot_d;
  logic          hsm_hit;

  for (genvar g = 0; g < NC; g++) begin : g_dec
    assign onehot_d[g] = vld_i && (int'(cls_i) == g);
  end

  assign hsm_hit = vld_i && (cls_i == CL_HSM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      onehot_o <= '0;
      rreq_o   <= 1'b0;
    end else begin
      vld_o    <= vld_i;
      onehot_o <= onehot_d;
      if (hsm_hit)    rreq_o <= 1'b1;
      else if (clr_i) rreq_o <= 1'b0;
    end
  end

  p_one_class_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ($countones(onehot_o) == 1));
  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (onehot_o == '0));
  p_hsm_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && onehot_o[CL_HSM]) |-> rreq_o);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rreq_o && !clr_i) |=> rreq_o);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hsm_hit) |=> !rreq_o);
endmodule

// File: rtl/ata_fault_sorter.sv
module ata_fault_sorter
  import ata_fault_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             atapi_i,
  input  logic             cdb_done_i,
  input  logic [ST_W-1:0]  status_i,
  input  logic [ER_W-1:0]  error_i,
  input  logic             reset_clr_i,
  output logic             cls_valid_o,
  output logic [N_CLS-1:0] cls_o,
  output logic             reset_req_o
);
  flags_t flags;
  cls_e   cls_d;

  ata_flag_extract #(.SW(ST_W), .EW(ER_W)) i_extract (
    .status_i (status_i),
    .error_i  (error_i),
    .flags_o  (flags)
  );

  ata_phase_rules i_rules (
    .phase_i    (phase_i),
    .atapi_i    (atapi_i),
    .cdb_done_i (cdb_done_i),
    .flags_i    (flags),
    .cls_o      (cls_d)
  );

  ata_class_reg #(.NC(N_CLS)) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (smp_valid_i),
    .cls_i    (cls_d),
    .clr_i    (reset_clr_i),
    .vld_o    (cls_valid_o),
    .onehot_o (cls_o),
    .rreq_o   (reset_req_o)
  );

  p_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> cls_valid_o);
  p_issue_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && phase_i == PH_ISSUE && !status_i[ST_BSY] && status_i[ST_DRDY]
     && !status_i[ST_DRQ]) |=> cls_o[CL_OK]);
  p_drq_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && phase_i == PH_DONE && status_i[ST_DRQ]) |=> cls_o[CL_HSM]);
  p_chk_after_cdb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && atapi_i && cdb_done_i && phase_i == PH_CDB && !status_i[ST_BSY]
     && status_i[ST_ERR]) |=> cls_o[CL_CHK]);
  p_bad_phase_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && phase_i > PH_DONE) |=> (cls_o[CL_HSM] && reset_req_o));
endmodule

// File: tb/test_ata_fault_sorter.sv
module test_ata_fault_sorter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [2:0] phase = '0;
  logic       atapi = 1'b0;
  logic       cdb_done = 1'b0;
  logic [7:0] status = '0;
  logic [7:0] error = '0;
  logic       clr = 1'b0;
  logic       cls_valid;
  logic [6:0] cls;
  logic       reset_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ata_fault_sorter i_ata_fault_sorter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_valid_i (smp_valid),
    .phase_i     (phase),
    .atapi_i     (atapi),
    .cdb_done_i  (cdb_done),
    .status_i    (status),
    .error_i     (error),
    .reset_clr_i (clr),
    .cls_valid_o (cls_valid),
    .cls_o       (cls),
    .reset_req_o (reset_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected class index from the requirement text
  function automatic int ref_cls(input int ph, input bit pk, input bit cd,
                                 input bit b, input bit dr, input bit q, input bit e,
                                 input bit ic, input bit un, input bit id, input bit ab,
                                 output string tag);
    bit quiet;
    quiet = !b && e;
    if (ph > 4) begin tag = "R10"; return 1; end
    if (ph == 0) begin tag = "R2"; return (!b && dr && !q) ? 0 : 1; end
    if (ph == 4 && q) begin tag = "R4"; return 1; end
    if ((ph == 1 || ph == 3) && !pk) begin tag = "R5"; return 1; end
    if (ph == 1) begin
      tag = "R6";
      if (!quiet) return 0;
      return ab ? 2 : 1;
    end
    if (quiet) begin
      if (!pk) begin
        tag = "R8";
        if (ic) return 6;
        if (un) return 4;
        if (id) return 5;
        return 2;
      end
      if (cd) begin tag = "R7"; return 3; end
      tag = "R5"; return 1;
    end
    if (ph == 2) begin tag = "R3"; return (!b && !q) ? 1 : 0; end
    tag = "R1";
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit rr_exp;
    int n;
    rr_exp = 1'b0;
    n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(cls_valid), 0);
    chk("R1 reset class", int'(cls), 0);
    chk("R9 reset flag", int'(reset_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int ph = 0; ph < 8; ph++)
      for (int pk = 0; pk < 2; pk++)
        for (int cd = 0; cd < 2; cd++)
          for (int s = 0; s < 16; s++)
            for (int e = 0; e < 16; e++) begin
              string tag;
              int exp;
              bit pulse;
              bit [3:0] junk;
              junk = 4'(s ^ e ^ ph ^ (n >> 3));
              pulse = (n % 29) == 5;
              phase    = 3'(ph);
              atapi    = pk[0];
              cdb_done = cd[0];
              status   = {s[3], s[2], junk[3:2], s[1], junk[1:0], s[0]};
              error    = {e[3], e[2], junk[0], e[1], junk[1], e[0], junk[3:2]};
              smp_valid = 1'b1;
              clr = pulse;
              exp = ref_cls(ph, pk[0], cd[0], s[3], s[2], s[1], s[0],
                            e[3], e[2], e[1], e[0], tag);
              if (exp == 1) rr_exp = 1'b1;
              else if (pulse) rr_exp = 1'b0;
              @(negedge clk);
              smp_valid = 1'b0;
              clr = 1'b0;
              chk("R1 strobe", int'(cls_valid), 1);
              chk(tag, int'(cls), 1 << exp);
              chk("R9 flag", int'(reset_req), int'(rr_exp));
              @(negedge clk);
              chk("R1 idle valid", int'(cls_valid), 0);
              chk("R1 idle class", int'(cls), 0);
              n++;
            end

    // clear with no strobe after a violation
    phase = 3'd6; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R10 class", int'(cls), 7'b0000010);
    chk("R9 set", int'(reset_req), 1);
    repeat (3) @(negedge clk);
    chk("R9 hold", int'(reset_req), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9 cleared", int'(reset_req), 0);
    @(negedge clk);
    chk("R9 stays clear", int'(reset_req), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule